// File: doc/BRIEF.md
# Grouped Pin Interrupt Summary

This block reduces a wide vector of per-pin pending flags to a compact summary. Each summary bit is the OR of four neighbouring pins, so 184 pins give 46 summary bits. The summary is registered and software reads it as two 32-bit words. The low word holds summary bits 0 to 31. The high word holds bits 32 to 45 and is padded with zeros.

A single shared interrupt line goes to the host. It fires when any summary bit is set and the line is armed. Once it fires it latches high and disarms. Software services the pins and then writes an end-of-interrupt bit in a master control word. That write drops the line and re-arms it. If pins are still pending at that point, the line comes back one cycle later. The per-pin edge or level detection that produces the pending flags sits upstream and is outside this block.

Top module: `pin_irq_summary`

## Requirements
- R1: While reset is active and right after it, `irq_out` is 0, both summary words read 0, and the line is armed.
- R2: Summary bit k is the OR of pins 4k, 4k+1, 4k+2 and 4k+3. It shows in the read data one clock edge after the pending vector changes.
- R3: A read at byte offset 0x0 returns summary bits 0 to 31 in data bits 0 to 31.
- R4: A read at byte offset 0x4 returns summary bits 32 to 45 in data bits 0 to 13. Data bits 14 to 31 read 0.
- R5: When armed, `irq_out` rises at the clock edge after the registered summary becomes nonzero. That is two edges after the pending flag appears.
- R6: Once high, `irq_out` stays high, even after all pending flags clear, until an end-of-interrupt write.
- R7: A write to byte offset 0x8 with data bit 5 set is an end-of-interrupt. It drives `irq_out` to 0 at that edge and re-arms the line.
- R8: If the summary is still nonzero after an end-of-interrupt, `irq_out` re-asserts at the following edge.
- R9: A read at offset 0x8 returns 0. The end-of-interrupt bit 5 is self-clearing and never reads back as 1.
- R10: The following writes leave `irq_out` unchanged:
  - a write to offset 0x8 with bit 5 clear;
  - any write to offset 0x0;
  - any write to offset 0xC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_pending | input | 184 | Per-pin pending flags |
| bus_addr | input | 4 | Register byte offset for reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_out | output | 1 | Shared interrupt to the host |

## Verification
There is one register stage from pending flags to summary, so the summary words are due one edge after a pending change. The interrupt takes one more stage and is due two edges after the change. An end-of-interrupt acts at the edge that samples the write, and a re-assertion follows one edge after that. The bench drives inputs at falling edges and samples outputs in the low phase, just after the edge where each result is due. It checks the line both before and after that edge, to confirm the result is not a cycle early.

// File: rtl/pis_pkg.sv
package pis_pkg;
    // Byte offsets of the register words
    localparam logic [3:0] OFS_SUM_LO = 4'h0;
    localparam logic [3:0] OFS_SUM_HI = 4'h4;
    localparam logic [3:0] OFS_MASTER = 4'h8;

    // Position of the end-of-interrupt bit in the master word
    localparam int EOI_BIT = 5;

    typedef struct packed {
        logic armed;
        logic irq;
    } line_state_t;
endpackage

// File: rtl/pis_group_or.sv
module pis_group_or #(
    parameter int NUM_PINS   = 184,
    parameter int GROUP_SIZE = 4,
    localparam int NUM_GROUPS = NUM_PINS / GROUP_SIZE
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_pending,
    output logic [NUM_GROUPS-1:0] summary
);
    logic [NUM_GROUPS-1:0] grp_or;
    logic [NUM_GROUPS-1:0] summary_d, summary_q;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign grp_or[g] = |pin_pending[g*GROUP_SIZE +: GROUP_SIZE];
    end

    always_comb begin
        summary_d = grp_or;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) summary_q <= '0;
        else        summary_q <= summary_d;
    end

    assign summary = summary_q;

    AST_SUM_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((|summary_q) == (|$past(pin_pending[NUM_GROUPS*GROUP_SIZE-1:0])))); // R2
endmodule

// File: rtl/pis_irq_arm.sv
module pis_irq_arm
    import pis_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic summary_any,
    input  logic eoi,
    output logic irq
);
    line_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (eoi) begin
            st_d.irq   = 1'b0;
            st_d.armed = 1'b1;
        end else if (st_q.armed && summary_any) begin
            st_d.irq   = 1'b1;
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.armed <= 1'b1;
            st_q.irq   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !eoi) |=> irq); // R6
    AST_EOI_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        eoi |=> !irq); // R7
    AST_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (!eoi && !irq && summary_any) |=> irq); // R5
    AST_ARM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.armed && st_q.irq)); // R8
endmodule

// File: rtl/pis_read_mux.sv
module pis_read_mux
    import pis_pkg::*;
#(
    parameter int NUM_GROUPS = 46,
    parameter int DATA_W     = 32,
    localparam int HI_BITS   = NUM_GROUPS - DATA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_GROUPS-1:0] summary,
    input  logic [3:0]            bus_addr,
    output logic [DATA_W-1:0]     bus_rdata
);
    localparam logic [DATA_W-1:0] HI_MASK = DATA_W'((64'd1 << HI_BITS) - 64'd1);

    logic [2*DATA_W-1:0] padded;
    assign padded = (2*DATA_W)'(summary);

    always_comb begin
        unique case (bus_addr)
            OFS_SUM_LO: bus_rdata = padded[DATA_W-1:0];
            OFS_SUM_HI: bus_rdata = padded[2*DATA_W-1:DATA_W];
            default:    bus_rdata = '0;
        endcase
    end

    AST_HI_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_SUM_HI) |-> ((bus_rdata & ~HI_MASK) == '0)); // R4
    AST_MASTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_MASTER) |-> (bus_rdata == '0)); // R9
endmodule

// File: rtl/pin_irq_summary.sv
module pin_irq_summary
    import pis_pkg::*;
#(
    parameter int NUM_PINS   = 184,
    parameter int GROUP_SIZE = 4,
    parameter int DATA_W     = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_pending,
    input  logic [3:0]          bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                irq_out
);
    localparam int NUM_GROUPS = NUM_PINS / GROUP_SIZE;

    logic [NUM_GROUPS-1:0] summary;
    logic                  eoi;
    logic                  unused_wdata;

    assign eoi          = bus_wr && (bus_addr == OFS_MASTER) && bus_wdata[EOI_BIT];
    assign unused_wdata = ^bus_wdata;

    pis_group_or #(.NUM_PINS(NUM_PINS), .GROUP_SIZE(GROUP_SIZE)) i_group_or (
        .clk(clk), .rst_n(rst_n), .pin_pending(pin_pending), .summary(summary)
    );

    pis_irq_arm i_irq_arm (
        .clk(clk), .rst_n(rst_n), .summary_any(|summary), .eoi(eoi), .irq(irq_out)
    );

    pis_read_mux #(.NUM_GROUPS(NUM_GROUPS), .DATA_W(DATA_W)) i_read_mux (
        .clk(clk), .rst_n(rst_n), .summary(summary), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !irq_out); // R1
endmodule

// File: tb/test_pin_irq_summary.sv
module test_pin_irq_summary;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 184;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_pending = '0;
    logic [3:0]    bus_addr = 4'h0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_irq_summary i_pin_irq_summary (
        .clk(clk), .rst_n(rst_n), .pin_pending(pin_pending), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    // {pin index, expected low word, expected high word}
    localparam int NV = 9;
    localparam logic [71:0] VEC [NV] = '{
        {8'd0,   32'h0000_0001, 32'h0},
        {8'd3,   32'h0000_0001, 32'h0},
        {8'd4,   32'h0000_0002, 32'h0},
        {8'd61,  32'h0000_8000, 32'h0},
        {8'd127, 32'h8000_0000, 32'h0},
        {8'd128, 32'h0,         32'h0000_0001},
        {8'd131, 32'h0,         32'h0000_0001},
        {8'd170, 32'h0,         32'h0000_0400},
        {8'd183, 32'h0,         32'h0000_2000}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    initial begin
        logic [31:0] d;
        @(negedge clk);
        rd(4'h0, d); check("R1 lo in reset", d, 32'h0);
        rd(4'h4, d); check("R1 hi in reset", d, 32'h0);
        check("R1 irq in reset", {31'b0, irq_out}, 32'h0);
        tick(); tick();
        rst_n = 1'b1;
        tick();
        check("R1 irq after reset", {31'b0, irq_out}, 32'h0);

        // Vector table: R2/R3/R4 mapping
        for (int i = 0; i < NV; i++) begin
            pin_pending = '0;
            pin_pending[VEC[i][71:64]] = 1'b1;
            tick();
            rd(4'h0, d); check($sformatf("R3 lo pin %0d", VEC[i][71:64]), d, VEC[i][63:32]);
            rd(4'h4, d); check($sformatf("R4 hi pin %0d", VEC[i][71:64]), d, VEC[i][31:0]);
        end
        pin_pending = '0;
        tick();
        wr(4'h8, 32'h20);   // clear the line raised by the table walk
        tick();
        check("R7 clean start", {31'b0, irq_out}, 32'h0);

        // R2: several pins in one group, and one-edge latency
        pin_pending[11:8] = 4'hF;
        pin_pending[101]  = 1'b1;
        rd(4'h0, d); check("R2 not before edge", d, 32'h0);
        tick();
        rd(4'h0, d); check("R2 group OR", d, 32'h0200_0004);
        check("R5 not yet", {31'b0, irq_out}, 32'h0);
        tick();
        check("R5 irq rises", {31'b0, irq_out}, 32'h1);

        // R6: held after pending clears
        pin_pending = '0;
        tick(); tick(); tick();
        check("R6 irq held", {31'b0, irq_out}, 32'h1);

        // R10: non-EOI writes have no effect
        wr(4'h8, 32'hFFFF_FFDF);
        check("R10 master bit5 clear", {31'b0, irq_out}, 32'h1);
        wr(4'h0, 32'h20);
        check("R10 write lo", {31'b0, irq_out}, 32'h1);
        wr(4'hC, 32'h20);
        check("R10 write 0xC", {31'b0, irq_out}, 32'h1);

        // R9: master reads zero
        rd(4'h8, d); check("R9 master read", d, 32'h0);

        // R7: EOI drops the line; nothing pending so it stays low
        wr(4'h8, 32'h20);
        check("R7 eoi drop", {31'b0, irq_out}, 32'h0);
        rd(4'h8, d); check("R9 eoi self-clear", d, 32'h0);
        tick(); tick();
        check("R7 stays low", {31'b0, irq_out}, 32'h0);

        // R8: EOI while still pending re-asserts next edge
        pin_pending[50] = 1'b1;
        tick(); tick();
        check("R5 fire again", {31'b0, irq_out}, 32'h1);
        wr(4'h8, 32'h20);
        check("R8 drop at eoi", {31'b0, irq_out}, 32'h0);
        tick();
        check("R8 re-assert", {31'b0, irq_out}, 32'h1);
        rd(4'h0, d); check("R2 pin 50", d, 32'h0000_1000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule